// File: doc/BRIEF.md
# Banked Lane Scratchpad

This block is an on-chip scratchpad of 256 words of 32 bits, split into 16 banks. It serves read requests from a group of 16 parallel lanes. Each lane gives an 8-bit word address and a valid bit. The low four address bits select the bank and the high four bits select the row inside that bank. Each bank serves one distinct address per pass, and a pass takes two clock cycles. Lanes whose addresses collide in a bank at different rows are therefore spread over several passes. Lanes that share an address are served together, so a group in which every lane reads one word finishes in a single broadcast pass.

A group is accepted when `req_valid` is high while `ready` is high. All lane inputs are captured on that edge. The state machine has four states:

- `ST_IDLE`: ready for a new group; the write port is live.
- `ST_FETCH`: every bank with pending lanes reads the address of its lowest-numbered pending lane.
- `ST_CAPTURE`: each lane served in this pass latches its word and leaves the pending set.
- `ST_FINISH`: `done` pulses and `pass_cnt` reports the number of passes.

The transitions are:

- Accept with at least one valid lane: `ST_IDLE` → `ST_FETCH`.
- Accept with no valid lane: `ST_IDLE` → `ST_FINISH`.
- Always: `ST_FETCH` → `ST_CAPTURE`.
- Lanes still pending: `ST_CAPTURE` → `ST_FETCH`.
- Nothing left: `ST_CAPTURE` → `ST_FINISH`.
- Always: `ST_FINISH` → `ST_IDLE`.

The write port loads one word per cycle, and only while the block is idle.

Top module: `lane_scratchpad`

## Requirements
- R1: Word address A is stored in bank A[3:0] at row A[7:4]. A write with `wr_en` high while `ready` is high stores `wr_data` at `wr_addr` on that clock edge, one word per cycle, and a later read of A returns that word.
- R2: After reset, `ready` is 1, `done` is 0, `pass_cnt` is 0 and all `rd_data` is 0. A group is accepted on a rising edge where `req_valid` and `ready` are both 1. `ready` is 0 from the next cycle until the group has finished.
- R3: A group whose valid lanes all use different banks finishes in one pass. `done` is high in the cycle after the second edge following acceptance, and `pass_cnt` is 1.
- R4: A group whose valid lanes all read the same address finishes in one broadcast pass, and every valid lane receives that word.
- R5: The pass count is the largest number of distinct addresses among valid lanes that map to any one bank. `done` is high in the cycle after edge 2×N following the accepting edge, where N is the pass count, and `pass_cnt` shows N.
- R6: While `done` is high, each valid lane's field of `rd_data` holds the word stored at that lane's address. Lane i uses `lane_addr[8i+7:8i]` and `rd_data[32i+31:32i]`.
- R7: Invalid lanes are left out of conflict counting and their read data is 0. A group with no valid lane finishes with N = 0, with `done` high in the cycle right after the accepting edge.
- R8: `done` is a one-cycle pulse, and `ready` returns the next cycle. `rd_data` and `pass_cnt` hold their values until the next group is accepted.
- R9: A write attempted while `ready` is 0 has no effect on the memory contents.
- R10: In each pass, each bank serves the address of its lowest-numbered pending lane, together with every pending lane at that same address. At least one lane completes in every pass, and the pending set only shrinks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request group present |
| ready | output | 1 | Block idle, can accept a group or a write |
| lane_vld | input | 16 | Per-lane valid bits |
| lane_addr | input | 128 | Per-lane 8-bit word addresses, lane 0 in the low bits |
| done | output | 1 | One-cycle pulse at the end of a group |
| pass_cnt | output | 5 | Passes used by the last group |
| rd_data | output | 512 | Per-lane 32-bit read data, lane 0 in the low bits |
| wr_en | input | 1 | Write strobe, honoured only when idle |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 32 | Write data |

## Verification
The bench aims at several corner cases of the pass count:

- **Strides 1, 2, 3, 4, 8 and 16.** These give 1, 2, 1, 4, 8 and 16 passes. A design with a wrong bank mapping, or one that counts lanes instead of distinct addresses, reports the wrong pass count and finishes at the wrong cycle.
- **Broadcast and shared-address mixes.** A design that does not merge equal addresses takes extra passes.
- **Groups with invalid lanes.** A design that counts invalid lanes adds passes or returns stale data on those lanes.
- **Writes while busy.** A design that does not gate writes with the idle state corrupts a word that a later group reads back.

Random groups drawn from small address pools mix these cases against a reference model of the pass count.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_FINISH  = 2'd3
    } sp_state_e;

endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              re,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_row] <= wr_word;
        end
        if (re) begin
            rd_word <= mem[rd_row];
        end
    end

endmodule

// File: rtl/sp_bank_arbiter.sv
module sp_bank_arbiter #(
    parameter int LANES  = 16,
    parameter int BANKS  = 16,
    parameter int ADDR_W = 8
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    output logic [BANKS-1:0]        bank_act,
    output logic [BANKS*ADDR_W-1:0] bank_addr_flat,
    output logic [LANES-1:0]        served
);

    localparam int BANK_W = $clog2(BANKS);

    logic [ADDR_W-1:0] lane_a [LANES];
    logic [ADDR_W-1:0] sel_a  [BANKS];

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_a[l] = addr_flat[l*ADDR_W +: ADDR_W];
        end
    end

    // Per bank: scan from the top so the lowest-numbered pending lane wins.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_act[b] = 1'b0;
            sel_a[b]    = '0;
            for (int l = LANES - 1; l >= 0; l--) begin
                if (pending[l] && (lane_a[l][BANK_W-1:0] == BANK_W'(b))) begin
                    bank_act[b] = 1'b1;
                    sel_a[b]    = lane_a[l];
                end
            end
            bank_addr_flat[b*ADDR_W +: ADDR_W] = sel_a[b];
        end
    end

    // Every pending lane whose address matches its bank's pick rides along.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            served[l] = pending[l] && (lane_a[l] == sel_a[lane_a[l][BANK_W-1:0]]);
        end
    end

endmodule

// File: rtl/lane_scratchpad.sv
module lane_scratchpad #(
    parameter int LANES  = 16,
    parameter int BANKS  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     ready,
    input  logic [LANES-1:0]         lane_vld,
    input  logic [LANES*ADDR_W-1:0]  lane_addr,
    output logic                     done,
    output logic [$clog2(LANES+1)-1:0] pass_cnt,
    output logic [LANES*DATA_W-1:0]  rd_data,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data
);

    import sp_pkg::*;

    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int CNT_W  = $clog2(LANES + 1);

    sp_state_e state, nxt;

    logic [LANES-1:0]        vld_q;
    logic [LANES-1:0]        pending;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]       rd_q      [LANES];
    logic [DATA_W-1:0]       lane_word [LANES];
    logic [DATA_W-1:0]       bank_rd   [BANKS];
    logic [CNT_W-1:0]        pass_q;

    logic [BANKS-1:0]        bank_act;
    logic [BANKS*ADDR_W-1:0] bank_addr;
    logic [LANES-1:0]        served;
    logic                    accept;

    assign accept = (state == ST_IDLE) && req_valid;

    sp_bank_arbiter #(
        .LANES (LANES),
        .BANKS (BANKS),
        .ADDR_W(ADDR_W)
    ) u_arb (
        .pending       (pending),
        .addr_flat     (addr_q),
        .bank_act      (bank_act),
        .bank_addr_flat(bank_addr),
        .served        (served)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_we;
        logic bank_re;
        assign bank_we = wr_en && (state == ST_IDLE)
                         && (wr_addr[BANK_W-1:0] == BANK_W'(b));
        assign bank_re = (state == ST_FETCH) && bank_act[b];

        sp_bank #(
            .DATA_W(DATA_W),
            .ROW_W (ROW_W)
        ) u_bank (
            .clk    (clk),
            .we     (bank_we),
            .wr_row (wr_addr[ADDR_W-1:BANK_W]),
            .wr_word(wr_data),
            .re     (bank_re),
            .rd_row (bank_addr[b*ADDR_W+BANK_W +: ROW_W]),
            .rd_word(bank_rd[b])
        );
    end

    // Route each lane to the bank its address selects.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_word[l] = bank_rd[addr_q[l*ADDR_W +: BANK_W]];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt = (|lane_vld) ? ST_FETCH : ST_FINISH;
                end
            end
            ST_FETCH:   nxt = ST_CAPTURE;
            ST_CAPTURE: nxt = (|(pending & ~served)) ? ST_FETCH : ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Lane datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            pending <= '0;
            addr_q  <= '0;
            pass_q  <= '0;
            for (int l = 0; l < LANES; l++) begin
                rd_q[l] <= '0;
            end
        end else if (accept) begin
            vld_q   <= lane_vld;
            pending <= lane_vld;
            addr_q  <= lane_addr;
            pass_q  <= '0;
            for (int l = 0; l < LANES; l++) begin
                rd_q[l] <= '0;
            end
        end else if (state == ST_CAPTURE) begin
            pending <= pending & ~served;
            pass_q  <= pass_q + 1'b1;
            for (int l = 0; l < LANES; l++) begin
                if (served[l]) begin
                    rd_q[l] <= lane_word[l];
                end
            end
        end
    end

    // Outputs
    always_comb begin
        ready    = (state == ST_IDLE);
        done     = (state == ST_FINISH);
        pass_cnt = pass_q;
        for (int l = 0; l < LANES; l++) begin
            rd_data[l*DATA_W +: DATA_W] = rd_q[l];
        end
    end

    // R10
    serve_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE) |-> (served != '0));

    // R10
    pending_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE) |=> ((($past(pending) & ~pending) != '0)
                                   && ((pending & ~$past(pending)) == '0)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    // R5
    pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass_cnt <= CNT_W'(LANES)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R7
        idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !vld_q[l]) |-> (rd_q[l] == '0));
    end

endmodule

// File: tb/lane_scratchpad_tb.sv
module lane_scratchpad_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         ready;
    logic [15:0]  lane_vld = '0;
    logic [127:0] lane_addr = '0;
    logic         done;
    logic [4:0]   pass_cnt;
    logic [511:0] rd_data;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [31:0] ref_mem [256];
    bit          g_vld   [LANES];
    logic [7:0]  g_addr  [LANES];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_scratchpad u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
        .lane_vld(lane_vld), .lane_addr(lane_addr), .done(done),
        .pass_cnt(pass_cnt), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference pass count: max distinct addresses per bank among valid lanes.
    function automatic int calc_passes();
        int per_bank [16];
        int best = 0;
        for (int b = 0; b < 16; b++) per_bank[b] = 0;
        for (int i = 0; i < LANES; i++) begin
            bit seen = 1'b0;
            if (!g_vld[i]) continue;
            for (int j = 0; j < i; j++) begin
                if (g_vld[j] && g_addr[j] == g_addr[i]) seen = 1'b1;
            end
            if (!seen) per_bank[g_addr[i][3:0]]++;
        end
        for (int b = 0; b < 16; b++) if (per_bank[b] > best) best = per_bank[b];
        return best;
    endfunction

    task automatic write_word(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        ref_mem[a] = d;
    endtask

    // Runs the group in g_vld/g_addr. A busy write, if requested, is never applied to ref_mem.
    task automatic run_group(input string tag, input bit busy_wr,
                             input logic [7:0] bw_addr);
        int lat = 0;
        int exp_n;
        logic [4:0] pc_keep;
        logic [31:0] d0_keep;
        for (int i = 0; i < LANES; i++) begin
            lane_vld[i] = g_vld[i];
            lane_addr[i*8 +: 8] = g_addr[i];
        end
        exp_n = calc_passes();
        check(ready == 1'b1, "R2", "ready before accept", 32'(ready), 1);
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (exp_n > 0) check(ready == 1'b0, "R2", "ready while busy", 32'(ready), 0);
        while (!done && lat < 100) begin
            if (busy_wr && lat == 0) begin
                wr_en = 1'b1; wr_addr = bw_addr; wr_data = ~ref_mem[bw_addr];
            end
            @(posedge clk); #1;
            wr_en = 1'b0;
            lat++;
        end
        check(lat == 2*exp_n, tag, "done latency", 32'(lat), 32'(2*exp_n));
        check(pass_cnt == 5'(exp_n), tag, "pass_cnt", 32'(pass_cnt), 32'(exp_n));
        for (int i = 0; i < LANES; i++) begin
            logic [31:0] e = g_vld[i] ? ref_mem[g_addr[i]] : 32'h0;
            check(rd_data[i*32 +: 32] == e, g_vld[i] ? "R6" : "R7",
                  $sformatf("lane %0d data", i), rd_data[i*32 +: 32], e);
        end
        pc_keep = pass_cnt;
        d0_keep = rd_data[31:0];
        @(posedge clk); #1;
        check(done == 1'b0 && ready == 1'b1, "R8", "done pulse ends",
              32'({done, ready}), 32'b01);
        @(posedge clk); #1;
        check(pass_cnt == pc_keep && rd_data[31:0] == d0_keep, "R8", "outputs hold",
              rd_data[31:0], d0_keep);
    endtask

    task automatic set_all(input bit v);
        for (int i = 0; i < LANES; i++) g_vld[i] = v;
    endtask

    task automatic stride_group(input logic [7:0] base, input int s, input string tag);
        set_all(1'b1);
        for (int i = 0; i < LANES; i++) g_addr[i] = 8'(base + s*i);
        run_group(tag, 1'b0, 8'h0);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!finished) begin
            fails++;
            $display("FAIL R2 watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd24601);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R2 reset state
        check(ready == 1'b1, "R2", "reset ready", 32'(ready), 1);
        check(done == 1'b0, "R2", "reset done", 32'(done), 0);
        check(pass_cnt == 5'd0, "R2", "reset pass_cnt", 32'(pass_cnt), 0);
        check(rd_data == '0, "R2", "reset rd_data", rd_data[31:0], 0);

        // R1 preload every word
        for (int a = 0; a < 256; a++) write_word(8'(a), $urandom);

        // R3 stride 1: distinct banks
        stride_group(8'h20, 1, "R3");
        // R3 stride 3: still distinct banks
        stride_group(8'h05, 3, "R3");
        // R4 broadcast
        set_all(1'b1);
        for (int i = 0; i < LANES; i++) g_addr[i] = 8'h9C;
        run_group("R4", 1'b0, 8'h0);
        // R5 strides 2, 4, 8, 16
        stride_group(8'h00, 2, "R5");
        stride_group(8'h11, 4, "R5");
        stride_group(8'h03, 8, "R5");
        stride_group(8'h07, 16, "R5");
        // R7 no valid lanes
        set_all(1'b0);
        run_group("R7", 1'b0, 8'h0);
        // R7 invalid lanes colliding are not counted
        stride_group(8'h00, 16, "R5");
        for (int i = 1; i < LANES; i++) g_vld[i] = 1'b0;
        run_group("R7", 1'b0, 8'h0);
        // R10 mixed: lanes 0,1 share address, lane 2 same bank other row
        set_all(1'b0);
        g_vld[0] = 1; g_vld[1] = 1; g_vld[2] = 1;
        g_addr[0] = 8'h34; g_addr[1] = 8'h34; g_addr[2] = 8'h74;
        run_group("R10", 1'b0, 8'h0);
        // R9 write while busy, then read that word
        stride_group(8'h00, 2, "R5");
        g_addr[0] = 8'h00; g_addr[1] = 8'h10;
        run_group("R9", 1'b1, 8'h5A);
        set_all(1'b1);
        for (int i = 0; i < LANES; i++) g_addr[i] = 8'h5A;
        run_group("R9", 1'b0, 8'h0);
        // R1 rewrite and read back
        write_word(8'hE7, 32'hCAFE_0123);
        stride_group(8'hE7, 1, "R1");

        // Random groups
        for (int n = 0; n < 300; n++) begin
            int mode = int'($urandom % 6);
            logic [7:0] pool [3];
            for (int k = 0; k < 3; k++) pool[k] = 8'($urandom);
            for (int i = 0; i < LANES; i++) begin
                g_vld[i] = ($urandom % 4) != 0;
                unique case (mode)
                    0: g_addr[i] = 8'($urandom);
                    1: g_addr[i] = pool[$urandom % 3];
                    2: g_addr[i] = 8'(pool[0] + (1 << ($urandom % 5)) * i);
                    3: begin g_addr[i] = pool[0]; g_vld[i] = 1'b1; end
                    4: g_addr[i] = {4'(i), pool[1][3:0]};
                    default: begin g_addr[i] = 8'($urandom); g_vld[i] = ($urandom % 16) == 0; end
                endcase
            end
            if (mode == 2) begin
                int s = 1 << ($urandom % 5);
                for (int i = 0; i < LANES; i++) g_addr[i] = 8'(pool[0] + s*i);
            end
            if ($urandom % 8 == 0) write_word(8'($urandom), $urandom);
            run_group("R5", 1'b0, 8'h0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule